// File: doc/BRIEF.md
# Audio sample word formatter

This block sits behind a biphase decoder in an audio receiver. It takes one decoded sub-frame at a time and turns it into the 32-bit word that downstream logic reads. A sub-frame holds a 24-bit sample, four status flags (parity error, validity, user, channel status) and a 2-bit preamble type. The caller chooses one of three word layouts at run time and can hide any of the flag groups, which then read as zero. In the packed layout, two successive samples are reduced to 16 bits each and combined into one word. In mono operation only the first channel of each frame is kept.

Finished words wait in a one-entry output slot that a consumer drains with a valid/ready handshake. If a word is finished while the slot is still full, the new word is lost and a one-cycle overrun pulse is raised. A small state machine tracks packed pairing. It has three states. `PK_OFF` means the block is disabled. `PK_EMPTY` means no half word is pending. `PK_HALF` means the first packed sample is held.

The transitions are:
- From any state, deasserting `enable` moves to `PK_OFF`.
- `PK_OFF` moves to `PK_EMPTY` when enabled, or straight to `PK_HALF` when an accepted packed sample arrives in that same cycle.
- `PK_EMPTY` moves to `PK_HALF` on an accepted sample in packed layout.
- `PK_HALF` returns to `PK_EMPTY` on the second accepted sample, which emits the pair. It also returns to `PK_EMPTY` when the layout changes away from packed, and the held half is dropped.

Top module: `audio_word_fmt`

## Requirements
- R1: After reset, `out_valid` and `overrun` are both 0.
- R2: With `cfg_layout` = 00, the word is: sample in [23:0], parity error at bit 24, validity at 25, user at 26, channel status at 27, preamble type in [29:28], and zero in [31:30].
- R3: With `cfg_layout` = 01, the word is: parity error at bit 0, validity at 1, user at 2, channel status at 3, preamble type in [5:4], zero in [7:6], and the sample in [31:8].
- R4: With `cfg_layout` = 10, each accepted sample contributes its upper 16 bits. The first sample of a pair lands in [15:0] and the second in [31:16]. Exactly one word is produced per two accepted samples.
- R5: `cfg_layout` = 11 produces the same word as layout 00.
- R6: Each `cfg_hide` bit forces fields to zero. Bit 0 hides parity error, bit 1 hides validity, bit 2 hides both user and channel status, and bit 3 hides the preamble type.
- R7: With `cfg_stereo` = 1, sub-frames of both channels are formatted in arrival order. With `cfg_stereo` = 0, a sub-frame with `in_chan` = 1 is ignored and only `in_chan` = 0 sub-frames are used.
- R8: A word finished from a sample presented at clock edge N shows on `out_valid`/`out_word` after edge N. It stays stable until a cycle with `out_ready` high.
- R9: If a word is finished while the slot is full and not being drained in that cycle, the word is dropped. `overrun` then pulses for one cycle and the held word is unchanged. A word finished in the same cycle the slot drains is not lost.
- R10: While `enable` is low, samples are ignored. A packed half word still pending when `enable` falls is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low discards pending packed half |
| cfg_layout | input | 2 | Word layout: 00 right, 01 left, 10 packed, 11 as 00 |
| cfg_stereo | input | 1 | 1: both channels kept; 0: channel 0 only |
| cfg_hide | input | 4 | Field hide mask (parity, validity, user+status, preamble) |
| in_valid | input | 1 | Sub-frame strobe |
| in_sample | input | SAMPLE_W | Audio sample |
| in_perr | input | 1 | Parity error flag |
| in_vbit | input | 1 | Validity flag |
| in_ubit | input | 1 | User bit |
| in_csbit | input | 1 | Channel status bit |
| in_ptype | input | 2 | Preamble type |
| in_chan | input | 1 | Channel of the sub-frame (0 first, 1 second) |
| out_valid | output | 1 | Output slot holds a word |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | WORD_W | Formatted word |
| overrun | output | 1 | One-cycle pulse when a word is dropped |

## Verification
Every finished word is due one clock after the edge that accepted its sample. The overrun pulse is due in that same cycle and lasts one cycle. The bench changes inputs on the falling edge and reads outputs on the next falling edge, which is exactly one rising edge later. A packed first half, an ignored channel, or a sample taken while disabled must leave `out_valid` low at that same sampling point. Streaming runs drive a new sample every cycle with the consumer ready, and read each word one falling edge after its sample.

// File: rtl/awf_pkg.sv
package awf_pkg;

    typedef enum logic [1:0] {
        LAY_RIGHT  = 2'b00,
        LAY_LEFT   = 2'b01,
        LAY_PACKED = 2'b10,
        LAY_ALT    = 2'b11
    } lay_t;

    typedef enum logic [1:0] {
        PK_OFF   = 2'b00,
        PK_EMPTY = 2'b01,
        PK_HALF  = 2'b10
    } pk_state_t;

    localparam int FLAG_W = 4;
    localparam int PT_W   = 2;

endpackage

// File: rtl/awf_lane_map.sv
module awf_lane_map
    import awf_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int WORD_W   = 32
) (
    input  lay_t                lay,
    input  logic [FLAG_W-1:0]   hide,
    input  logic [SAMPLE_W-1:0] smp,
    input  logic [FLAG_W-1:0]   flags,
    input  logic [PT_W-1:0]     ptype,
    output logic [WORD_W-1:0]   word
);
    // flags: [0] parity error, [1] validity, [2] user, [3] channel status
    logic [FLAG_W-1:0] fl_m;
    logic [PT_W-1:0]   pt_m;

    always_comb begin
        fl_m = flags & ~{hide[2], hide[2], hide[1], hide[0]};
        pt_m = hide[3] ? '0 : ptype;
        word = '0;
        if (lay == LAY_LEFT) begin
            word[FLAG_W-1:0]              = fl_m;
            word[FLAG_W +: PT_W]          = pt_m;
            word[WORD_W-1 -: SAMPLE_W]    = smp;
        end else begin
            word[SAMPLE_W-1:0]            = smp;
            word[SAMPLE_W +: FLAG_W]      = fl_m;
            word[SAMPLE_W+FLAG_W +: PT_W] = pt_m;
        end
    end
endmodule

// File: rtl/awf_out_slot.sv
module awf_out_slot #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              rdy,
    output logic              vld,
    output logic [WORD_W-1:0] word,
    output logic              ovr
);
    logic busy;
    assign busy = vld && !rdy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            word <= '0;
            ovr  <= 1'b0;
        end else begin
            ovr <= push && busy;
            if (push && !busy) begin
                vld  <= 1'b1;
                word <= push_word;
            end else if (rdy) begin
                vld <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/audio_word_fmt.sv
module audio_word_fmt
    import awf_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int WORD_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [1:0]          cfg_layout,
    input  logic                cfg_stereo,
    input  logic [3:0]          cfg_hide,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                in_perr,
    input  logic                in_vbit,
    input  logic                in_ubit,
    input  logic                in_csbit,
    input  logic [1:0]          in_ptype,
    input  logic                in_chan,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WORD_W-1:0]   out_word,
    output logic                overrun
);
    localparam int HALF_W = WORD_W / 2;

    lay_t              lay;
    logic              packed_mode;
    logic              take;
    pk_state_t         state_q, state_d;
    logic [HALF_W-1:0] half_q;
    logic [WORD_W-1:0] mapped;
    logic              push;
    logic [WORD_W-1:0] push_word;

    assign lay         = lay_t'(cfg_layout);
    assign packed_mode = (lay == LAY_PACKED);
    assign take        = enable && in_valid && (cfg_stereo || !in_chan);

    awf_lane_map #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_map (
        .lay   (lay),
        .hide  (cfg_hide),
        .smp   (in_sample),
        .flags ({in_csbit, in_ubit, in_vbit, in_perr}),
        .ptype (in_ptype),
        .word  (mapped)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PK_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PK_OFF, PK_EMPTY: begin
                if (!enable)                  state_d = PK_OFF;
                else if (take && packed_mode) state_d = PK_HALF;
                else                          state_d = PK_EMPTY;
            end
            PK_HALF: begin
                if (!enable)                      state_d = PK_OFF;
                else if (!packed_mode || take)    state_d = PK_EMPTY;
            end
            default: state_d = PK_OFF;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        push      = 1'b0;
        push_word = mapped;
        unique case (state_q)
            PK_OFF, PK_EMPTY: push = take && !packed_mode;
            PK_HALF: begin
                push      = take && packed_mode;
                push_word = {in_sample[SAMPLE_W-1 -: HALF_W], half_q};
            end
            default: push = 1'b0;
        endcase
    end

    // first half of a packed pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            half_q <= '0;
        else if ((state_q != PK_HALF) && take && packed_mode)
            half_q <= in_sample[SAMPLE_W-1 -: HALF_W];
    end

    awf_out_slot #(.WORD_W(WORD_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_word (push_word),
        .rdy       (out_ready),
        .vld       (out_valid),
        .word      (out_word),
        .ovr       (overrun)
    );
endmodule

// File: rtl/awf_checker.sv
module awf_checker #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              cfg_stereo,
    input logic              in_valid,
    input logic              in_chan,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_word,
    input logic              overrun
);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    p_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && enable));

    p_ovr_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> out_valid);

    p_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && in_valid && !cfg_stereo && in_chan && !out_valid) |=> !out_valid);

    p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !out_valid) |=> !out_valid);
endmodule

bind audio_word_fmt awf_checker #(.WORD_W(WORD_W)) u_awf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cfg_stereo (cfg_stereo),
    .in_valid   (in_valid),
    .in_chan    (in_chan),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_word   (out_word),
    .overrun    (overrun)
);

// File: tb/audio_word_fmt_bench.sv
module audio_word_fmt_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic [1:0]  cfg_layout = 2'b00;
    logic        cfg_stereo = 1'b1;
    logic [3:0]  cfg_hide = 4'h0;
    logic        in_valid = 1'b0;
    logic [23:0] in_sample = '0;
    logic        in_perr = 1'b0, in_vbit = 1'b0, in_ubit = 1'b0, in_csbit = 1'b0;
    logic [1:0]  in_ptype = 2'b00;
    logic        in_chan = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_word;
    logic        overrun;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    audio_word_fmt u_audio_word_fmt (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_layout(cfg_layout),
        .cfg_stereo(cfg_stereo), .cfg_hide(cfg_hide), .in_valid(in_valid),
        .in_sample(in_sample), .in_perr(in_perr), .in_vbit(in_vbit),
        .in_ubit(in_ubit), .in_csbit(in_csbit), .in_ptype(in_ptype),
        .in_chan(in_chan), .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word), .overrun(overrun)
    );

    function automatic logic [31:0] exp_word(input logic [1:0] lay, input logic [3:0] hide,
                                             input logic [23:0] d, input logic [3:0] fl,
                                             input logic [1:0] pt);
        logic [3:0] f;
        logic [1:0] p;
        f = fl;
        if (hide[0]) f[0] = 1'b0;
        if (hide[1]) f[1] = 1'b0;
        if (hide[2]) begin f[2] = 1'b0; f[3] = 1'b0; end
        p = hide[3] ? 2'b00 : pt;
        if (lay == 2'b01) return {d, 2'b00, p, f};
        return {2'b00, p, f, d};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // present at negedge, withdraw at next negedge (one rising edge in between)
    task automatic send(input logic [23:0] d, input logic [3:0] fl, input logic [1:0] pt,
                        input logic ch);
        @(negedge clk);
        in_valid = 1'b1; in_sample = d; in_chan = ch; in_ptype = pt;
        {in_csbit, in_ubit, in_vbit, in_perr} = fl;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [23:0] a;
        logic [23:0] b;
        repeat (3) @(negedge clk);
        // R1
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 overrun", {31'd0, overrun}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after release", {31'd0, out_valid}, 32'd0);

        // R2 R3 R5 R6 sweep, R8 latency
        for (int li = 0; li < 3; li++) begin
            cfg_layout = (li == 0) ? 2'b00 : (li == 1) ? 2'b01 : 2'b11;
            for (int h = 0; h < 16; h++) begin
                for (int f = 0; f < 16; f++) begin
                    logic [23:0] d;
                    logic [1:0] pt;
                    cfg_hide = h[3:0];
                    d  = 24'h3A5C71 * (h + 1) ^ (f * 24'h010203);
                    pt = 2'((f + h) % 4);
                    send(d, f[3:0], pt, 1'b0);
                    check((li == 0) ? "R2 R6 R8 right word" : (li == 1) ? "R3 R6 R8 left word" : "R5 R6 alt word",
                          out_word, exp_word(cfg_layout, cfg_hide, d, f[3:0], pt));
                    check("R8 out_valid", {31'd0, out_valid}, 32'd1);
                end
            end
        end
        cfg_hide = 4'h0;

        // R7 stereo order and mono drop
        cfg_layout = 2'b00; cfg_stereo = 1'b1;
        send(24'h111111, 4'h0, 2'b01, 1'b0);
        check("R7 stereo first", out_word, exp_word(2'b00, 4'h0, 24'h111111, 4'h0, 2'b01));
        send(24'h222222, 4'h0, 2'b10, 1'b1);
        check("R7 stereo second", out_word, exp_word(2'b00, 4'h0, 24'h222222, 4'h0, 2'b10));
        cfg_stereo = 1'b0;
        @(negedge clk);
        send(24'h333333, 4'h0, 2'b00, 1'b1);
        check("R7 mono ignores chan 1", {31'd0, out_valid}, 32'd0);
        send(24'h444444, 4'h0, 2'b00, 1'b0);
        check("R7 mono keeps chan 0", out_word, exp_word(2'b00, 4'h0, 24'h444444, 4'h0, 2'b00));

        // R4 packed pairs
        cfg_layout = 2'b10; cfg_stereo = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            a = 24'h9137B5 * (k + 3);
            b = 24'h5E2D0F ^ (k * 24'h0F0F11);
            send(a, 4'hF, 2'b11, 1'b0);
            check("R4 first half no word", {31'd0, out_valid}, 32'd0);
            send(b, 4'hF, 2'b11, 1'b1);
            check("R4 packed word", out_word, {b[23:8], a[23:8]});
        end
        cfg_stereo = 1'b0;
        send(24'hABCDEF, 4'h0, 2'b00, 1'b0);
        send(24'h777777, 4'h0, 2'b00, 1'b1);
        check("R7 R4 mono chan 1 skipped", {31'd0, out_valid}, 32'd0);
        send(24'h123456, 4'h0, 2'b00, 1'b0);
        check("R7 R4 mono pair", out_word, {16'h1234, 16'hABCD});
        cfg_stereo = 1'b1;

        // R10 disable discards pending half and ignores samples
        send(24'hDEAD00, 4'h0, 2'b00, 1'b0);
        @(negedge clk);
        enable = 1'b0;
        send(24'hF00F00, 4'h0, 2'b00, 1'b0);
        check("R10 ignored while disabled", {31'd0, out_valid}, 32'd0);
        enable = 1'b1;
        send(24'hCAFE00, 4'h0, 2'b00, 1'b0);
        check("R10 half discarded", {31'd0, out_valid}, 32'd0);
        send(24'hBEEF00, 4'h0, 2'b00, 1'b0);
        check("R10 fresh pair", out_word, {16'hBEEF, 16'hCAFE});

        // R9 overrun
        cfg_layout = 2'b00;
        @(negedge clk);
        out_ready = 1'b0;
        send(24'h0000AA, 4'h0, 2'b00, 1'b0);
        check("R9 first held", out_word, 32'h000000AA);
        check("R9 no overrun yet", {31'd0, overrun}, 32'd0);
        send(24'h0000BB, 4'h0, 2'b00, 1'b0);
        check("R9 overrun pulse", {31'd0, overrun}, 32'd1);
        check("R9 held word kept", out_word, 32'h000000AA);
        @(negedge clk);
        check("R9 pulse one cycle", {31'd0, overrun}, 32'd0);
        check("R8 still stable", out_word, 32'h000000AA);
        out_ready = 1'b1;
        @(negedge clk);
        check("R8 drained", {31'd0, out_valid}, 32'd0);

        // R9 R8 back-to-back streaming with consumer ready
        @(negedge clk);
        in_valid = 1'b1; in_chan = 1'b0; in_ptype = 2'b00;
        {in_csbit, in_ubit, in_vbit, in_perr} = 4'h0;
        in_sample = 24'h000100;
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            check("R9 stream word", out_word, {8'h00, 24'h000100 * i});
            check("R9 stream no overrun", {31'd0, overrun}, 32'd0);
            if (i < 5) in_sample = 24'h000100 * (i + 1);
            else in_valid = 1'b0;
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule